// File: doc/BRIEF.md
# Resolver Converter Configuration Port

This block is the byte-oriented configuration port of a resolver-to-digital converter, reached over a four-wire serial link in clock-polarity-high, capture-on-rising mode (SPI mode 3). One byte stream carries both address and data, and bit 7 tells them apart. A byte with bit 7 set names a register. A byte with bit 7 clear is data for the register named last. A register is read by sending its address. Its value comes back on MISO during the following byte, which the host normally fills with 0xFF. Because 0xFF is itself the fault address, that filler byte also acts as a fault read.

The port holds seven 7-bit threshold registers at 0x88 to 0x8E, a 7-bit excitation frequency word at 0x91, a 7-bit control register at 0x92 and a fault latch read at 0xFF. Writing 0x00 to the soft-reset address 0xF0 restores the control register and the fault latch and forgets the pending address. The control register drives the resolution-select, hysteresis and lock-range outputs. The frequency word is driven out for the excitation generator. Fault conditions come in on an input vector. Two mode-select inputs decide whether the port is in configuration mode or whether the converter is serving position or velocity readout. In readout mode this port ignores the link.

Top module: `resolver_cfg_slave`

## Requirements
- R1: A byte is formed MSB first from MOSI sampled on 8 rising SCLK edges while CS_n is low. Raising CS_n discards a partly received byte and restarts the bit count.
- R2: A byte with bit 7 set is an address and becomes the pending address. A byte with bit 7 clear writes its low 7 bits to the pending address. Further data bytes keep writing the same address. A data byte with no pending address, after reset or after a soft reset, changes nothing.
- R3: After an address byte, MISO shifts out that register's value MSB first during the next byte. Readable registers return bit 7 = 0. Addresses outside the map, and 0xF0, return 0x00. The first byte of a frame and the byte after a data byte return 0x00. MISO is 0 while CS_n is high.
- R4: The control register resets to 0x7E. Its outputs are: res_sel = ctrl[1:0], with 00/01/10/11 meaning 10/12/14/16 bits; hyst_en = ctrl[4]; lock_range = ctrl[5].
- R5: The excitation word resets to 0x28 and accepts only values 0x04 to 0x50. A write outside that range leaves the word unchanged and sets freq_err. freq_err is cleared only by rst_n.
- R6: Addresses 0x88 to 0x8E each hold an independent 7-bit threshold that resets to 0x00 and reads back the value last written.
- R7: Address 0xF0 followed by data 0x00 sets control to 0x7E, clears the fault latch and clears the pending address. Thresholds and the excitation word are kept. Any other data value to 0xF0 has no effect.
- R8: The port acts only when sel_a0 = 1 and sel_a1 = 0. With 0,0 (position readout) or 0,1 (velocity readout), received bytes change no state and MISO stays 0.
- R9: An address byte 0xFF returns fault_latch | fault_in and stores that value in the latch. One cycle with sample_n low clears the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial link |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, idles high |
| spi_cs_n | input | 1 | Frame select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| sel_a0 | input | 1 | Mode select bit A0 |
| sel_a1 | input | 1 | Mode select bit A1 |
| sample_n | input | 1 | Active-low sample pulse, clears the fault latch |
| fault_in | input | 8 | Live fault condition bits |
| res_sel | output | 2 | Resolution select from the control register |
| hyst_en | output | 1 | Hysteresis enable |
| lock_range | output | 1 | Phase-lock range select |
| excit_fcw | output | 7 | Excitation frequency word |
| freq_err | output | 1 | Sticky flag for a rejected frequency write |

## Verification
Serial inputs pass a two-stage synchronizer and an edge register. A register write therefore reaches the outputs on the fourth system-clock edge after the eighth rising SCLK edge of its data byte. MISO changes three system clocks after each falling SCLK edge. The bench runs SCLK with half-periods of six system clocks and samples MISO just before it raises SCLK, so each read bit is taken well after it has settled. It compares the control and frequency outputs against its byte-level model on every clock, but only from ten clocks after CS_n rises until the next frame starts. This keeps the comparison clear of the pipeline latency.

// File: rtl/rcfg_pkg.sv
package rcfg_pkg;
   localparam int BYTE_BITS = 8;

   localparam logic [7:0] ADDR_FCW   = 8'h91;
   localparam logic [7:0] ADDR_CTRL  = 8'h92;
   localparam logic [7:0] ADDR_SRST  = 8'hF0;
   localparam logic [7:0] ADDR_FAULT = 8'hFF;

   // packing is {A0, A1}
   typedef enum logic [1:0] {
      MODE_POS = 2'b00,
      MODE_VEL = 2'b01,
      MODE_CFG = 2'b10,
      MODE_RSV = 2'b11
   } mode_e;

   typedef struct packed {
      logic       valid;
      logic [7:0] data;
   } byte_evt_t;
endpackage

// File: rtl/rcfg_sync.sv
module rcfg_sync #(
   parameter int         W       = 1,
   parameter int         STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] chain;

   initial begin : elab_chk
      assert (STAGES >= 2) else $error("rcfg_sync: STAGES must be at least 2");
   end

   for (genvar k = 0; k < STAGES; k++) begin : g_stg
      logic [W-1:0] stg_q;
      if (k == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q <= RST_VAL;
            else        stg_q <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q <= RST_VAL;
            else        stg_q <= chain[k-1];
         end
      end
      assign chain[k] = stg_q;
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/rcfg_spi_shift.sv
module rcfg_spi_shift
   import rcfg_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sclk,
   input  logic       cs_n,
   input  logic       mosi,
   input  logic       tx_load,
   input  logic [7:0] tx_data,
   output byte_evt_t  evt,
   output logic       miso
);
   localparam int CNT_W = $clog2(BYTE_BITS);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_BITS - 1);

   logic [2:0] raw_in, sync_out;
   logic sclk_s, cs_s, mosi_s, sclk_d;
   logic rise, fall;
   logic [CNT_W-1:0] bit_cnt;
   logic [BYTE_BITS-1:0] rx_sr, tx_sr;
   logic miso_q;

   assign raw_in = {sclk, cs_n, mosi};

   rcfg_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (sync_out)
   );

   assign {sclk_s, cs_s, mosi_s} = sync_out;
   assign rise = sclk_s & ~sclk_d;
   assign fall = ~sclk_s & sclk_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d  <= 1'b1;
         bit_cnt <= '0;
         rx_sr   <= '0;
         tx_sr   <= '0;
         miso_q  <= 1'b0;
         evt     <= '0;
      end else begin
         sclk_d    <= sclk_s;
         evt.valid <= 1'b0;
         if (cs_s) begin
            bit_cnt <= '0;
            rx_sr   <= '0;
            tx_sr   <= '0;
            miso_q  <= 1'b0;
         end else begin
            if (rise) begin
               rx_sr <= {rx_sr[BYTE_BITS-2:0], mosi_s};
               if (bit_cnt == LAST_BIT) begin
                  bit_cnt   <= '0;
                  evt.valid <= 1'b1;
                  evt.data  <= {rx_sr[BYTE_BITS-2:0], mosi_s};
               end else begin
                  bit_cnt <= bit_cnt + 1'b1;
               end
            end
            if (tx_load) begin
               tx_sr <= tx_data;
            end else if (fall) begin
               miso_q <= tx_sr[BYTE_BITS-1];
               tx_sr  <= {tx_sr[BYTE_BITS-2:0], 1'b0};
            end
         end
      end
   end

   assign miso = miso_q;

   // R1: a byte needs eight rising edges, so two events never abut
   p_evt_spaced_r1: assert property (@(posedge clk) disable iff (!rst_n)
      evt.valid |=> !evt.valid);

   // R1: frame release restarts the bit count
   p_cnt_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cs_s |=> (bit_cnt == '0));

   // R3: no data on MISO outside a frame
   p_miso_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cs_s |=> !miso_q);
endmodule

// File: rtl/rcfg_regfile.sv
module rcfg_regfile
   import rcfg_pkg::*;
#(
   parameter int         THR_COUNT = 7,
   parameter logic [7:0] THR_BASE  = 8'h88,
   parameter logic [6:0] THR_RST   = 7'h00,
   parameter logic [6:0] CTRL_RST  = 7'h7E,
   parameter logic [6:0] FCW_RST   = 7'h28,
   parameter logic [6:0] FCW_MIN   = 7'h04,
   parameter logic [6:0] FCW_MAX   = 7'h50
) (
   input  logic       clk,
   input  logic       rst_n,
   input  byte_evt_t  evt,
   input  logic       active,
   input  logic [7:0] fault_in,
   input  logic       sample_n,
   output logic [7:0] rd_data,
   output logic [1:0] res_sel,
   output logic       hyst_en,
   output logic       lock_range,
   output logic [6:0] excit_fcw,
   output logic       freq_err
);
   localparam int IDX_W = (THR_COUNT > 1) ? $clog2(THR_COUNT) : 1;
   localparam logic [7:0] THR_LAST = THR_BASE + 8'(THR_COUNT - 1);

   initial begin : elab_chk
      assert (THR_COUNT >= 1) else $error("rcfg_regfile: THR_COUNT must be positive");
      assert (THR_BASE[7]) else $error("rcfg_regfile: THR_BASE must have bit 7 set");
      assert (int'(THR_BASE) + THR_COUNT - 1 < int'(ADDR_FCW))
         else $error("rcfg_regfile: thresholds overlap the frequency address");
      assert (FCW_MIN <= FCW_MAX) else $error("rcfg_regfile: empty frequency range");
      assert (FCW_RST >= FCW_MIN && FCW_RST <= FCW_MAX)
         else $error("rcfg_regfile: frequency reset value outside range");
   end

   logic [7:0] paddr_q;
   logic       pend_q;
   logic [6:0] ctrl_q, fcw_q;
   logic       ferr_q;
   logic [7:0] flt_q;
   logic [THR_COUNT-1:0][6:0] thr_vals;

   logic       is_addr, is_data, srst;
   logic [6:0] wr_d;
   logic       fcw_ok, in_thr;
   logic [IDX_W-1:0] thr_idx;
   logic [7:0] flt_view;

   assign is_addr  = evt.valid & active &  evt.data[7];
   assign is_data  = evt.valid & active & ~evt.data[7] & pend_q;
   assign wr_d     = evt.data[6:0];
   assign srst     = is_data && (paddr_q == ADDR_SRST) && (wr_d == 7'd0);
   assign fcw_ok   = (wr_d >= FCW_MIN) && (wr_d <= FCW_MAX);
   assign flt_view = flt_q | fault_in;

   // address tracking
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         paddr_q <= '0;
         pend_q  <= 1'b0;
      end else if (is_addr) begin
         paddr_q <= evt.data;
         pend_q  <= 1'b1;
      end else if (srst) begin
         pend_q  <= 1'b0;
      end
   end

   // threshold bank
   for (genvar i = 0; i < THR_COUNT; i++) begin : g_thr
      localparam logic [7:0] MY_ADDR = THR_BASE + 8'(i);
      logic [6:0] val_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              val_q <= THR_RST;
         else if (is_data && paddr_q == MY_ADDR)  val_q <= wr_d;
      end
      assign thr_vals[i] = val_q;
   end

   // control register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    ctrl_q <= CTRL_RST;
      else if (srst)                                 ctrl_q <= CTRL_RST;
      else if (is_data && paddr_q == ADDR_CTRL)      ctrl_q <= wr_d;
   end

   // excitation word with range guard
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fcw_q  <= FCW_RST;
         ferr_q <= 1'b0;
      end else if (is_data && paddr_q == ADDR_FCW) begin
         if (fcw_ok) fcw_q  <= wr_d;
         else        ferr_q <= 1'b1;
      end
   end

   // fault latch: clear has priority over capture
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    flt_q <= '0;
      else if (!sample_n || srst)                    flt_q <= '0;
      else if (is_addr && evt.data == ADDR_FAULT)    flt_q <= flt_view;
   end

   // read-back value for the next outgoing byte
   assign in_thr  = (evt.data >= THR_BASE) && (evt.data <= THR_LAST);
   assign thr_idx = IDX_W'(evt.data - THR_BASE);

   always_comb begin
      rd_data = 8'h00;
      if (is_addr) begin
         if (in_thr) begin
            rd_data = {1'b0, thr_vals[thr_idx]};
         end else begin
            case (evt.data)
               ADDR_FCW:   rd_data = {1'b0, fcw_q};
               ADDR_CTRL:  rd_data = {1'b0, ctrl_q};
               ADDR_FAULT: rd_data = flt_view;
               default:    rd_data = 8'h00;
            endcase
         end
      end
   end

   assign res_sel    = ctrl_q[1:0];
   assign hyst_en    = ctrl_q[4];
   assign lock_range = ctrl_q[5];
   assign excit_fcw  = fcw_q;
   assign freq_err   = ferr_q;

   // R2: data with no pending address leaves state untouched
   p_orphan_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (evt.valid && !evt.data[7] && !pend_q) |=> ($stable(ctrl_q) && $stable(fcw_q)));

   // R5: rejected word leaves the register and raises the flag
   p_fcw_reject_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (is_data && paddr_q == ADDR_FCW && !fcw_ok) |=> ($stable(fcw_q) && ferr_q));

   // R5: error flag is sticky
   p_ferr_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ferr_q |=> ferr_q);

   // R7: soft reset restores control and drops the pending address
   p_srst_r7: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> (ctrl_q == CTRL_RST && !pend_q && flt_q == 8'h00));

   // R8: outside configuration mode nothing moves
   p_inactive_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (evt.valid && !active) |=> ($stable(ctrl_q) && $stable(paddr_q) && $stable(fcw_q)));

   // R9: sample pulse empties the fault latch
   p_fault_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_n |=> (flt_q == 8'h00));
endmodule

// File: rtl/resolver_cfg_slave.sv
module resolver_cfg_slave
   import rcfg_pkg::*;
#(
   parameter int         SYNC_STAGES = 2,
   parameter int         THR_COUNT   = 7,
   parameter logic [7:0] THR_BASE    = 8'h88,
   parameter logic [6:0] CTRL_RST    = 7'h7E,
   parameter logic [6:0] FCW_RST     = 7'h28,
   parameter logic [6:0] FCW_MIN     = 7'h04,
   parameter logic [6:0] FCW_MAX     = 7'h50
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       spi_sclk,
   input  logic       spi_cs_n,
   input  logic       spi_mosi,
   output logic       spi_miso,
   input  logic       sel_a0,
   input  logic       sel_a1,
   input  logic       sample_n,
   input  logic [7:0] fault_in,
   output logic [1:0] res_sel,
   output logic       hyst_en,
   output logic       lock_range,
   output logic [6:0] excit_fcw,
   output logic       freq_err
);
   mode_e      mode;
   logic       active;
   byte_evt_t  evt;
   logic [7:0] rd_data;
   logic       miso_raw;

   assign mode   = mode_e'({sel_a0, sel_a1});
   assign active = (mode == MODE_CFG);

   rcfg_spi_shift #(.SYNC_STAGES(SYNC_STAGES)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .sclk    (spi_sclk),
      .cs_n    (spi_cs_n),
      .mosi    (spi_mosi),
      .tx_load (evt.valid),
      .tx_data (rd_data),
      .evt     (evt),
      .miso    (miso_raw)
   );

   rcfg_regfile #(
      .THR_COUNT (THR_COUNT),
      .THR_BASE  (THR_BASE),
      .THR_RST   (7'h00),
      .CTRL_RST  (CTRL_RST),
      .FCW_RST   (FCW_RST),
      .FCW_MIN   (FCW_MIN),
      .FCW_MAX   (FCW_MAX)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt        (evt),
      .active     (active),
      .fault_in   (fault_in),
      .sample_n   (sample_n),
      .rd_data    (rd_data),
      .res_sel    (res_sel),
      .hyst_en    (hyst_en),
      .lock_range (lock_range),
      .excit_fcw  (excit_fcw),
      .freq_err   (freq_err)
   );

   assign spi_miso = miso_raw & active;

   // R8: readout modes keep MISO low
   p_miso_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> !spi_miso);
endmodule

// File: tb/resolver_cfg_slave_bench.sv
module resolver_cfg_slave_bench;
   localparam int HALF = 6;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n = 1'b0, sclk = 1'b1, cs_n = 1'b1, mosi = 1'b0;
   logic sel_a0 = 1'b1, sel_a1 = 1'b0, sample_n = 1'b1;
   logic [7:0] fault_in = 8'h00;
   logic miso, hyst_en, lock_range, freq_err;
   logic [1:0] res_sel;
   logic [6:0] excit_fcw;

   resolver_cfg_slave u_resolver_cfg_slave (
      .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
      .spi_mosi(mosi), .spi_miso(miso), .sel_a0(sel_a0), .sel_a1(sel_a1),
      .sample_n(sample_n), .fault_in(fault_in), .res_sel(res_sel),
      .hyst_en(hyst_en), .lock_range(lock_range), .excit_fcw(excit_fcw),
      .freq_err(freq_err)
   );

   int vectors = 0, miscompares = 0;
   bit done = 1'b0, cmp_en = 1'b0;

   // behavioural model state
   int m_thr[7];
   int m_ctrl = 'h7E, m_fcw = 'h28, m_flt = 0, m_addr = 0, exp_miso = 0;
   bit m_ferr = 1'b0, m_pend = 1'b0;
   logic [7:0] tx_q[$];

   task automatic check(input string tag, input string what, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic int m_read(input int a);
      if (a >= 'h88 && a <= 'h8E) return m_thr[a - 'h88];
      if (a == 'h91) return m_fcw;
      if (a == 'h92) return m_ctrl;
      if (a == 'hFF) return m_flt | int'(fault_in);
      return 0;
   endfunction

   task automatic m_byte(input int b);
      if (!(sel_a0 && !sel_a1)) begin
         exp_miso = 0;
         return;
      end
      if (b >= 'h80) begin
         exp_miso = m_read(b);
         m_addr = b;
         m_pend = 1'b1;
         if (b == 'hFF) m_flt = m_flt | int'(fault_in);
      end else begin
         exp_miso = 0;
         if (m_pend) begin
            if (m_addr >= 'h88 && m_addr <= 'h8E) m_thr[m_addr - 'h88] = b;
            else if (m_addr == 'h91) begin
               if (b >= 'h04 && b <= 'h50) m_fcw = b;
               else m_ferr = 1'b1;
            end else if (m_addr == 'h92) m_ctrl = b;
            else if (m_addr == 'hF0 && b == 0) begin
               m_ctrl = 'h7E;
               m_flt = 0;
               m_pend = 1'b0;
            end
         end
      end
   endtask

   task automatic xfer(input logic [7:0] tx, input string tag);
      logic [7:0] rx;
      rx = 8'h00;
      for (int i = 7; i >= 0; i--) begin
         @(negedge clk);
         sclk = 1'b0;
         mosi = tx[i];
         repeat (HALF) @(negedge clk);
         rx[i] = miso;
         sclk = 1'b1;
         repeat (HALF - 1) @(negedge clk);
      end
      check(tag, "miso byte", int'(rx), exp_miso);
      m_byte(int'(tx));
      repeat (2) @(negedge clk);
   endtask

   task automatic run(input string tag);
      cmp_en = 1'b0;
      @(negedge clk);
      cs_n = 1'b0;
      exp_miso = 0;
      repeat (4) @(negedge clk);
      while (tx_q.size() > 0) xfer(tx_q.pop_front(), tag);
      repeat (HALF) @(negedge clk);
      cs_n = 1'b1;
      repeat (10) @(negedge clk);
      cmp_en = 1'b1;
   endtask

   task automatic partial(input int nbits);
      cmp_en = 1'b0;
      @(negedge clk);
      cs_n = 1'b0;
      repeat (4) @(negedge clk);
      for (int i = 0; i < nbits; i++) begin
         sclk = 1'b0; mosi = 1'b1;
         repeat (HALF) @(negedge clk);
         sclk = 1'b1;
         repeat (HALF) @(negedge clk);
      end
      cs_n = 1'b1;
      repeat (10) @(negedge clk);
      cmp_en = 1'b1;
   endtask

   task automatic pulse_sample();
      @(negedge clk); sample_n = 1'b0;
      @(negedge clk); sample_n = 1'b1;
      m_flt = 0;
      repeat (2) @(negedge clk);
   endtask

   // per-clock comparison of the static outputs against the model
   always @(negedge clk) begin
      if (cmp_en) begin
         check("R4", "res_sel", int'(res_sel), m_ctrl & 3);
         check("R4", "hyst_en", int'(hyst_en), (m_ctrl >> 4) & 1);
         check("R4", "lock_range", int'(lock_range), (m_ctrl >> 5) & 1);
         check("R5", "excit_fcw", int'(excit_fcw), m_fcw);
         check("R5", "freq_err", int'(freq_err), int'(m_ferr));
         check("R3", "idle miso", int'(miso), 0);
      end
   end

   initial begin
      for (int i = 0; i < 7; i++) m_thr[i] = 0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      // reset state
      check("R4", "reset res_sel (14 bits)", int'(res_sel), 2);
      check("R4", "reset hyst_en", int'(hyst_en), 1);
      check("R4", "reset lock_range", int'(lock_range), 1);
      check("R5", "reset fcw", int'(excit_fcw), 'h28);
      check("R5", "reset freq_err", int'(freq_err), 0);
      check("R3", "reset miso", int'(miso), 0);
      cmp_en = 1'b1;

      // R2: orphan data after reset, then read control
      tx_q = '{8'h33, 8'h92, 8'hFF};
      run("R2");

      // R4: write control, read back
      tx_q = '{8'h92, 8'h01, 8'h92, 8'hFF};
      run("R4");
      check("R4", "res_sel after 0x01", int'(res_sel), 1);

      // R1: aborted partial byte must not shift later bytes
      partial(3);
      tx_q = '{8'h92, 8'hFF};
      run("R1");

      // R6: write all thresholds then stream them back
      for (int i = 0; i < 7; i++) begin
         tx_q.push_back(8'(8'h88 + i));
         tx_q.push_back(8'(8'h11 * (i + 1)));
      end
      run("R6");
      for (int i = 0; i < 7; i++) tx_q.push_back(8'(8'h88 + i));
      tx_q.push_back(8'hFF);
      run("R6");

      // R5: range edges and rejection
      tx_q = '{8'h91, 8'h04, 8'h91, 8'hFF};
      run("R5");
      tx_q = '{8'h91, 8'h50};
      run("R5");
      tx_q = '{8'h91, 8'h51, 8'h91, 8'hFF};
      run("R5");
      check("R5", "fcw after 0x51", int'(excit_fcw), 'h50);
      check("R5", "freq_err after 0x51", int'(freq_err), 1);
      tx_q = '{8'h91, 8'h03, 8'h91, 8'h20};
      run("R5");

      // R2: repeated data bytes hit the same address
      tx_q = '{8'h92, 8'h12, 8'h23, 8'h92, 8'hFF};
      run("R2");
      check("R2", "hyst_en after 0x23", int'(hyst_en), 0);
      check("R2", "lock_range after 0x23", int'(lock_range), 1);

      // R3: unmapped and soft-reset addresses read zero
      tx_q = '{8'h85, 8'hF0, 8'hFF};
      run("R3");

      // R7: non-zero data to 0xF0 ignored, zero resets
      tx_q = '{8'hF0, 8'h05, 8'h92, 8'hFF};
      run("R7");
      tx_q = '{8'hF0, 8'h00, 8'h01};
      run("R7");
      check("R7", "ctrl after soft reset", int'(res_sel), 2);
      tx_q = '{8'h88, 8'h8E, 8'h91, 8'hFF};
      run("R7");

      // R8: readout modes ignore the link
      sel_a0 = 1'b0; sel_a1 = 1'b0;
      tx_q = '{8'h92, 8'h03, 8'h92, 8'hFF};
      run("R8");
      sel_a0 = 1'b0; sel_a1 = 1'b1;
      tx_q = '{8'h91, 8'h30, 8'h92, 8'hFF};
      run("R8");
      sel_a0 = 1'b1; sel_a1 = 1'b0;
      tx_q = '{8'h92, 8'h91, 8'hFF};
      run("R8");

      // R9: fault latch holds until sample pulse
      fault_in = 8'h05;
      tx_q = '{8'hFF, 8'hFF};
      run("R9");
      fault_in = 8'h00;
      tx_q = '{8'hFF, 8'hFF};
      run("R9");
      pulse_sample();
      tx_q = '{8'hFF, 8'hFF};
      run("R9");
      fault_in = 8'h30;
      tx_q = '{8'hFF, 8'hFF};
      run("R9");
      fault_in = 8'h00;
      tx_q = '{8'hF0, 8'h00, 8'hFF, 8'hFF};
      run("R7");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      #1500000;
      if (!done) begin
         miscompares++;
         $display("FAIL R1 watchdog actual=hung expected=complete");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule